// File: doc/BRIEF.md
# Wake pin interrupt detector bank

This block watches a small bank of external wake pins (up to eight, already synchronised to the clock). Each pin has its own configuration word that picks one trigger condition: low level, high level, falling edge, rising edge, either edge, or no trigger. Every pin that meets its condition sets a pending bit in a shared status word. A shared enable word masks those pending bits. One interrupt output rises whenever a pin is both pending and enabled. Software acknowledges a pin by writing a one to its bit in a clear word.

Edges are found by a small tracker state machine inside each pin. It has three states: TRK_UNKNOWN, where no earlier sample exists (after reset or after a re-arm), TRK_LOW and TRK_HIGH. The transitions are:

- TRK_UNKNOWN to TRK_LOW or TRK_HIGH: takes the first sample and reports no edge.
- TRK_LOW to TRK_HIGH: reports a rise.
- TRK_HIGH to TRK_LOW: reports a fall.
- Any state to TRK_UNKNOWN: a write to the pin's re-arm bit.

The pending bit of each pin is a sticky flag. It is set by a trigger hit and cleared by a clear write or by a re-arm.

Access is through a plain 32-bit register port with byte addresses. A request is a valid pulse with a write flag. Read data is registered and appears on the cycle after the read request.

Top module: `wake_pin_bank`

## Requirements
- R1: After reset, every pin's mode field reads 4 (no trigger), the status and enable words read 0, and the interrupt output is low.
- R2: The address map is as follows. Status is at 0x310 and is read-only. Enable is at 0x314 and is read/write; its low bits map one per pin, pin 0 in bit 0. Clear is at 0x318 and reads 0. Configuration for pin n is at 0x330 + 8·n. Every other address, including 0x31C and 0x334, reads 0. Read data appears on rd_data in the cycle after the read request and holds until the next read.
- R3: Each configuration word has three fields. Bit 0 returns the live pin level. Bits [3:1] return the mode exactly as last written. Bit 4 always reads 0.
- R4: The edge modes are 2 (falling), 3 (rising) and 6 (either edge). In these modes, the pin's status bit is set after the clock edge at which the sampled level differs from the previous sample in the chosen direction. The bit then stays set until it is cleared.
- R5: The level modes are 0 (low) and 1 (high). In these modes, the status bit is set after every clock edge at which the level condition holds. A clear has no lasting effect while the condition holds. Once the condition ends, the bit stays set until it is cleared.
- R6: Mode codes 4, 5 and 7 never set a status bit, whatever the pin does.
- R7: Writing the clear word clears each pin whose bit is 1. Pins whose bit is 0 are left unchanged.
- R8: When a clear write for a pin and a new trigger hit for that pin fall on the same clock edge, the status bit stays set.
- R9: Writing a configuration word with bit 4 set has two effects. It clears that pin's status, ignoring any hit on the same edge. It also discards the pin's previous sample, so the next sample is not taken as an edge.
- R10: irq_o is high exactly when some pin is both pending and enabled. It follows a status or enable change in the same cycle that change is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Synchronised wake pin levels |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can act on the same pin on the same clock edge: a software clear and a fresh trigger hit. The bench provokes this in two ways. It raises a rise-mode pin in the very cycle that carries the clear write for that pin. It also writes the clear word while a level-mode pin holds its condition. In both cases it reads the status word back, and the behavioural model expects the bit to remain set. A second overlap is also provoked: a re-arm write lands on the same edge as a falling edge. Here the model expects the status to stay clear and the next sample to pass without an edge.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

    localparam int unsigned REG_W         = 32;
    localparam int unsigned OFS_STATUS    = 'h310;
    localparam int unsigned OFS_ENABLE    = 'h314;
    localparam int unsigned OFS_CLEAR     = 'h318;
    localparam int unsigned OFS_CFG_BASE  = 'h330;
    localparam int unsigned CFG_STRIDE    = 8;

    // configuration word field positions
    localparam int unsigned CFG_LVL_BIT   = 0;
    localparam int unsigned CFG_MODE_LSB  = 1;
    localparam int unsigned CFG_MODE_MSB  = 3;
    localparam int unsigned CFG_REARM_BIT = 4;

    typedef enum logic [2:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_NONE = 3'd4,
        TRIG_BOTH = 3'd6
    } trig_e;

    typedef enum logic [1:0] {
        TRK_UNKNOWN = 2'd0,
        TRK_LOW     = 2'd1,
        TRK_HIGH    = 2'd2
    } trk_e;

    function automatic int unsigned cfg_offset(input int unsigned idx);
        return OFS_CFG_BASE + CFG_STRIDE * idx;
    endfunction

endpackage

// File: rtl/wpd_pin_cell.sv
module wpd_pin_cell
    import wpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       cfg_we_i,
    input  logic [2:0] cfg_mode_i,
    input  logic       rearm_i,
    input  logic       clr_i,
    output logic       pend_o,
    output logic [2:0] mode_o
);

    trk_e       trk_q;
    trk_e       trk_d;
    logic       rise;
    logic       fall;
    logic       hit;
    logic       pend_q;
    logic       pend_d;
    logic [2:0] mode_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= TRK_UNKNOWN;
        end else begin
            trk_q <= trk_d;
        end
    end

    // next state and edge outputs
    always_comb begin
        trk_d = trk_q;
        rise  = 1'b0;
        fall  = 1'b0;
        if (rearm_i) begin
            trk_d = TRK_UNKNOWN;
        end else begin
            unique case (trk_q)
                TRK_UNKNOWN: trk_d = pin_i ? TRK_HIGH : TRK_LOW;
                TRK_LOW: begin
                    if (pin_i) begin
                        trk_d = TRK_HIGH;
                        rise  = 1'b1;
                    end
                end
                TRK_HIGH: begin
                    if (!pin_i) begin
                        trk_d = TRK_LOW;
                        fall  = 1'b1;
                    end
                end
                default: trk_d = TRK_UNKNOWN;
            endcase
        end
    end

    // trigger condition under the current mode
    always_comb begin
        unique case (mode_q)
            TRIG_LOW:  hit = !pin_i;
            TRIG_HIGH: hit = pin_i;
            TRIG_FALL: hit = fall;
            TRIG_RISE: hit = rise;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        if (rearm_i) begin
            pend_d = 1'b0;
        end else begin
            pend_d = hit | (pend_q & ~clr_i);
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            mode_q <= TRIG_NONE;
        end else begin
            pend_q <= pend_d;
            if (cfg_we_i) begin
                mode_q <= cfg_mode_i;
            end
        end
    end

    assign pend_o = pend_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/wpd_regif.sv
module wpd_regif
    import wpd_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [REG_W-1:0]         req_wdata,
    input  logic [NUM_PINS-1:0]      pend_i,
    input  logic [NUM_PINS-1:0][2:0] mode_i,
    input  logic [NUM_PINS-1:0]      pin_i,
    output logic [NUM_PINS-1:0]      en_o,
    output logic [NUM_PINS-1:0]      clr_o,
    output logic [NUM_PINS-1:0]      cfg_we_o,
    output logic [NUM_PINS-1:0]      rearm_o,
    output logic [REG_W-1:0]         rd_data_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

    logic                wr_en;
    logic                rd_en;
    logic                sel_status;
    logic                sel_enable;
    logic                sel_clear;
    logic [NUM_PINS-1:0] sel_cfg;
    logic [NUM_PINS-1:0] en_q;
    logic [REG_W-1:0]    rd_mux;
    logic [REG_W-1:0]    rd_q;

    assign wr_en      = req_valid && req_write;
    assign rd_en      = req_valid && !req_write;
    assign sel_status = (req_addr == A_STATUS);
    assign sel_enable = (req_addr == A_ENABLE);
    assign sel_clear  = (req_addr == A_CLEAR);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(cfg_offset(g));
        assign sel_cfg[g]  = (req_addr == A_CFG);
        assign cfg_we_o[g] = wr_en && sel_cfg[g];
        assign rearm_o[g]  = wr_en && sel_cfg[g] && req_wdata[CFG_REARM_BIT];
    end

    assign clr_o = (wr_en && sel_clear) ? req_wdata[NUM_PINS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && sel_enable) begin
            en_q <= req_wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_status) begin
            rd_mux[NUM_PINS-1:0] = pend_i;
        end
        if (sel_enable) begin
            rd_mux[NUM_PINS-1:0] = en_q;
        end
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_cfg[i]) begin
                rd_mux[CFG_LVL_BIT]                = pin_i[i];
                rd_mux[CFG_MODE_MSB:CFG_MODE_LSB]  = mode_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign en_o      = en_q;
    assign rd_data_o = rd_q;

endmodule

// File: rtl/wake_pin_bank.sv
module wake_pin_bank
    import wpd_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [REG_W-1:0]    req_wdata,
    output logic [REG_W-1:0]    rd_data,
    output logic                irq_o
);

    logic [NUM_PINS-1:0]      pend_vec;
    logic [NUM_PINS-1:0]      en_vec;
    logic [NUM_PINS-1:0]      clr_vec;
    logic [NUM_PINS-1:0]      cfg_we;
    logic [NUM_PINS-1:0]      rearm;
    logic [NUM_PINS-1:0][2:0] mode_vec;

    wpd_regif #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pend_i    (pend_vec),
        .mode_i    (mode_vec),
        .pin_i     (pin_i),
        .en_o      (en_vec),
        .clr_o     (clr_vec),
        .cfg_we_o  (cfg_we),
        .rearm_o   (rearm),
        .rd_data_o (rd_data)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wpd_pin_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pin_i[g]),
            .cfg_we_i   (cfg_we[g]),
            .cfg_mode_i (req_wdata[CFG_MODE_MSB:CFG_MODE_LSB]),
            .rearm_i    (rearm[g]),
            .clr_i      (clr_vec[g]),
            .pend_o     (pend_vec[g]),
            .mode_o     (mode_vec[g])
        );
    end

    assign irq_o = |(pend_vec & en_vec);

endmodule

// File: rtl/wake_pin_bank_chk.sv
module wake_pin_bank_chk #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_PINS-1:0]       pin_i,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [ADDR_W-1:0]         req_addr,
    input logic [31:0]               req_wdata,
    input logic                      irq_o,
    input logic [NUM_PINS-1:0]       pend_vec,
    input logic [NUM_PINS-1:0][2:0]  mode_vec
);

    logic past_ok;
    logic wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign wr = req_valid && req_write;

    // R10
    en_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == ADDR_W'('h314) && req_wdata[NUM_PINS-1:0] == '0) |=> !irq_o);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        logic clr_g;
        logic rearm_g;
        assign clr_g   = wr && req_addr == ADDR_W'('h318) && req_wdata[g];
        assign rearm_g = wr && req_addr == ADDR_W'('h330 + 8 * g) && req_wdata[4];

        // R4
        pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[g] && !clr_g && !rearm_g) |=> pend_vec[g]);

        // R6
        none_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_vec[g] == 3'd4 || mode_vec[g] == 3'd5 || mode_vec[g] == 3'd7) && clr_g)
            |=> !pend_vec[g]);

        // R5
        level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[g] == 3'd1 && pin_i[g] && !rearm_g) |=> pend_vec[g]);

        // R9
        rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rearm_g |=> !pend_vec[g]);

        // R8
        rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && mode_vec[g] == 3'd3 && !$past(pin_i[g]) && pin_i[g]
             && !rearm_g && !$past(rearm_g)) |=> pend_vec[g]);
    end

endmodule

bind wake_pin_bank wake_pin_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .irq_o     (irq_o),
    .pend_vec  (pend_vec),
    .mode_vec  (mode_vec)
);

// File: tb/wake_pin_bank_tb.sv
module wake_pin_bank_tb;

    localparam int  NP         = 8;
    localparam int  AW         = 12;
    localparam time CLK_PERIOD = 10ns;

    localparam logic [AW-1:0] A_ST  = 12'h310;
    localparam logic [AW-1:0] A_EN  = 12'h314;
    localparam logic [AW-1:0] A_CLR = 12'h318;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rd_data;
    logic          irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wake_pin_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .irq_o     (irq)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    int          m_mode [NP];
    bit          m_pend [NP];
    bit          m_en   [NP];
    bit          m_prev [NP];
    bit          m_known[NP];
    logic [31:0] rd_expq[$];

    function automatic logic [AW-1:0] cfg_a(input int i);
        return AW'(32'h330 + 8 * i);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // one clock of the reference model, then compare at the falling edge
    task automatic tick();
        bit          n_pend [NP];
        bit          n_known[NP];
        bit          n_prev [NP];
        int          n_mode [NP];
        bit          n_en   [NP];
        bit          wr;
        bit          rd;
        bit          exp_irq;
        logic [31:0] rv;
        wr = req_valid && req_write;
        rd = req_valid && !req_write;
        rv = '0;
        for (int i = 0; i < NP; i++) begin
            bit cfgw, rearm, clr, rise, fall, hit;
            cfgw  = wr && (req_addr == cfg_a(i));
            rearm = cfgw && req_wdata[4];
            clr   = wr && (req_addr == A_CLR) && req_wdata[i];
            rise  = m_known[i] && !m_prev[i] && pin[i];
            fall  = m_known[i] && m_prev[i] && !pin[i];
            case (m_mode[i])
                0:       hit = !pin[i];
                1:       hit = pin[i];
                2:       hit = fall;
                3:       hit = rise;
                6:       hit = rise || fall;
                default: hit = 1'b0;
            endcase
            if (rearm) begin
                n_pend[i]  = 1'b0;
                n_known[i] = 1'b0;
            end else begin
                n_pend[i]  = hit || (m_pend[i] && !clr);
                n_known[i] = 1'b1;
            end
            n_prev[i] = pin[i];
            n_mode[i] = cfgw ? int'(req_wdata[3:1]) : m_mode[i];
            n_en[i]   = (wr && req_addr == A_EN) ? req_wdata[i] : m_en[i];
            if (rd && req_addr == A_ST) rv[i] = m_pend[i];
            if (rd && req_addr == A_EN) rv[i] = m_en[i];
            if (rd && req_addr == cfg_a(i)) rv = 32'(m_mode[i] * 2 + int'(pin[i]));
        end
        if (rd) rd_expq.push_back(rv);
        @(posedge clk);
        exp_irq = 1'b0;
        for (int i = 0; i < NP; i++) begin
            m_pend[i]  = n_pend[i];
            m_known[i] = n_known[i];
            m_prev[i]  = n_prev[i];
            m_mode[i]  = n_mode[i];
            m_en[i]    = n_en[i];
            exp_irq    = exp_irq || (m_pend[i] && m_en[i]);
        end
        @(negedge clk);
        chk(cur_req, "irq_o", 32'(irq), 32'(exp_irq));
        if (rd) chk(cur_req, "rd_data", rd_data, rd_expq.pop_front());
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        tick();
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NP; i++) begin
            m_mode[i] = 4; m_pend[i] = 0; m_en[i] = 0; m_prev[i] = 0; m_known[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        rd(A_ST); rd(A_EN); rd(cfg_a(0)); rd(cfg_a(7));

        cur_req = "R2";
        rd(12'h31C); rd(12'h334); rd(12'h000); rd(A_CLR);
        wr(A_ST, 32'hFF); rd(A_ST);

        cur_req = "R3";
        wr(cfg_a(0), 32'h6);  wr(cfg_a(1), 32'h4);  wr(cfg_a(2), 32'hC);
        wr(cfg_a(3), 32'h2);  wr(cfg_a(4), 32'h0);  wr(cfg_a(5), 32'hA);
        wr(cfg_a(6), 32'hE);  wr(cfg_a(7), 32'h18);
        rd(cfg_a(5)); rd(cfg_a(6)); rd(cfg_a(7));
        pin[2] = 1'b1; rd(cfg_a(2)); pin[2] = 1'b0; idle(1);
        wr(A_CLR, 32'hFF);

        cur_req = "R5";
        wr(A_EN, 32'hFF); rd(A_ST);
        wr(A_CLR, 32'h10); rd(A_ST);
        pin[4] = 1'b1; idle(1); rd(A_ST);
        wr(A_CLR, 32'h10); rd(A_ST);
        pin[3] = 1'b1; idle(1); wr(A_CLR, 32'h08); rd(A_ST);
        pin[3] = 1'b0; idle(1); rd(A_ST); wr(A_CLR, 32'h08); rd(A_ST);

        cur_req = "R4";
        pin[0] = 1'b1; idle(1); rd(A_ST);
        pin[0] = 1'b0; wr(A_CLR, 32'h01); rd(A_ST);
        pin[1] = 1'b1; idle(1); rd(A_ST); pin[1] = 1'b0; idle(1); rd(A_ST);
        pin[2] = 1'b1; idle(1); wr(A_CLR, 32'h06); pin[2] = 1'b0; idle(1); rd(A_ST);
        wr(A_CLR, 32'hFF);

        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            pin[7:5] = ~pin[7:5]; idle(1);
        end
        rd(A_ST);

        cur_req = "R8";
        wr(A_CLR, 32'h01); rd(A_ST);
        pin[0] = 1'b1; wr(A_CLR, 32'h01); rd(A_ST);

        cur_req = "R7";
        wr(A_CLR, 32'h00); rd(A_ST);
        wr(A_CLR, 32'h01); rd(A_ST);

        cur_req = "R9";
        pin[1] = 1'b1; idle(2);
        pin[1] = 1'b0; wr(cfg_a(1), 32'h14); idle(2); rd(A_ST); rd(cfg_a(1));
        pin[1] = 1'b1; idle(1); pin[1] = 1'b0; idle(1); rd(A_ST);

        cur_req = "R10";
        wr(A_EN, 32'h00); idle(1);
        wr(A_EN, 32'h02); rd(A_EN);
        wr(A_CLR, 32'hFF); idle(1);

        cur_req = "R4";
        wr(A_EN, 32'hFF);
        lf = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pin = lf[NP-1:0];
            if (k % 16 == 5)       wr(A_CLR, {24'h0, lf[15:8]});
            else if (k % 50 == 9)  wr(A_EN, {24'h0, lf[11:4]});
            else if (k % 8 == 3)   rd(A_ST);
            else                   tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule